// File: doc/BRIEF.md
# Latch-Strobed Serial Control Port

This block receives 16-bit control words over three wires: a shift clock, a data line and a latch strobe. All three lines arrive from outside the chip's clock domain. They are synchronized into the system clock. Data is shifted in MSB first on each rising edge of the shift clock. A rising edge of the latch strobe commits the shifted word to a small register file. The shift clock may run continuously, or it may be gated and stop for any length of time between bits or between words. Word boundaries are set only by the latch strobe.

The register file holds three things: a configuration word, a left volume and a right volume. The configuration word covers serial data format, word length, sample-rate range, de-emphasis, per-channel mute, output phase and master-clock direction. Each field leaves the block decoded and registered, and the audio datapath and clock blocks use these fields. A synchronous active-high reset returns every register to its default value.

Top module: `ctl_port`

## Requirements
- R1: A bit is taken from the data line on each rising edge of the shift clock. Bits enter MSB first, so the first bit shifted ends up in word bit 15.
- R2: A word is written only on a rising edge of the latch strobe, and only if exactly 16 bits have been shifted since the previous latch or reset. A latch after fewer than 16 bits changes no register.
- R3: A latch after more than 16 shifted bits changes no register.
- R4: The shift state (bits and count) clears on every latch edge, whether or not the word was accepted. The next 16 bits then form a fresh word.
- R5: The shift clock may stop at any level-low point between bits, for any number of cycles, and the word is still assembled correctly.
- R6: Word bits [15:14] select the register and bits [13:0] carry its data. Address 0 is the configuration register, address 1 the left volume (14 bits) and address 2 the right volume (14 bits). Registers that are not written hold their value.
- R7: A word with address 3 changes no register.
- R8: In the configuration register the fields sit at these data bits:
  - [1:0] serial format: 0 I2S, 1 left-justified, 2 right-justified, 3 DSP.
  - [3:2] word length: 0 16-bit, 1 20-bit, 2 24-bit.
  - [5:4] rate range: 0 base, 1 double, 2 quad.
  - [7:6] de-emphasis: 0 off, 1 32k, 2 44.1k, 3 48k.
  - [8] left mute.
  - [9] right mute.
  - [10] phase invert.
  - [11] master clock as input.
  - [13:12] are ignored.
- R9: While rst is high, the registers go to their defaults: format I2S, 24-bit length, base rate, de-emphasis off, no mute, normal phase, master clock as output, and both volumes 14'h3FFF. A partly shifted word is also dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_clk | input | 1 | Serial shift clock (asynchronous) |
| ctl_dat | input | 1 | Serial data, MSB first |
| ctl_latch | input | 1 | Latch strobe; rising edge commits the word |
| fmt_mode | output | 2 | Serial data format |
| word_len | output | 2 | Audio word length |
| rate_sel | output | 2 | Sample-rate range |
| deemph_sel | output | 2 | De-emphasis selection |
| mute_l | output | 1 | Left channel mute |
| mute_r | output | 1 | Right channel mute |
| phase_inv | output | 1 | Output phase invert |
| mclk_in_mode | output | 1 | Master clock is an input when high |
| vol_l | output | 14 | Left channel volume |
| vol_r | output | 14 | Right channel volume |

## Verification
A miscounted or uncleared bit counter does not show at once. It shows on the next latch, a few system cycles after the strobe edge: a good word is dropped and the outputs do not move, or a malformed word is accepted and a register jumps. A wrong shift order or a wrong address decode shows on the next committed word, with the value landing in the wrong field or the wrong register. Because every output is the direct value of a register, checking the outputs about a dozen cycles after each latch shows every such fault.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 2;
    localparam int DATA_W = WORD_W - ADDR_W;
    localparam int VOL_W  = 14;

    typedef enum logic [1:0] {FMT_I2S, FMT_LEFT, FMT_RIGHT, FMT_DSP} fmt_e;
    typedef enum logic [1:0] {WL_16, WL_20, WL_24, WL_RSVD} wlen_e;
    typedef enum logic [1:0] {RATE_BASE, RATE_DOUBLE, RATE_QUAD, RATE_RSVD} rate_e;
    typedef enum logic [1:0] {DEEM_OFF, DEEM_32K, DEEM_44K, DEEM_48K} deem_e;
    typedef enum logic [1:0] {ADDR_CFG, ADDR_VOL_L, ADDR_VOL_R, ADDR_RSVD} addr_e;

    // Field order follows the data bit positions (MSB first).
    typedef struct packed {
        logic  mclk_in;
        logic  phase_inv;
        logic  mute_r;
        logic  mute_l;
        deem_e deemph;
        rate_e rate;
        wlen_e wlen;
        fmt_e  fmt;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    localparam cfg_t CFG_DEFAULT = '{
        mclk_in:   1'b0,
        phase_inv: 1'b0,
        mute_r:    1'b0,
        mute_l:    1'b0,
        deemph:    DEEM_OFF,
        rate:      RATE_BASE,
        wlen:      WL_24,
        fmt:       FMT_I2S
    };

    localparam logic [VOL_W-1:0] VOL_DEFAULT = '1;

    function automatic cfg_t to_cfg(input logic [CFG_W-1:0] bits);
        return cfg_t'(bits);
    endfunction

endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] level
);

    logic [N-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= async_in;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign level = stg[STAGES-1];

endmodule

// File: rtl/ctl_shifter.sv
module ctl_shifter #(
    parameter int WORD_W = ctl_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_lvl,
    input  logic              sdat_lvl,
    input  logic              slat_lvl,
    output logic              word_vld,
    output logic [WORD_W-1:0] word
);

    localparam int CNT_MAX = WORD_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [WORD_W-1:0] sr;
    logic [CNT_W-1:0]  cnt;
    logic              sclk_prev, slat_prev;
    logic              bit_rise, strobe_rise;

    assign bit_rise    = sclk_lvl & ~sclk_prev;
    assign strobe_rise = slat_lvl & ~slat_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr        <= '0;
            cnt       <= '0;
            sclk_prev <= 1'b0;
            slat_prev <= 1'b0;
            word_vld  <= 1'b0;
            word      <= '0;
        end else begin
            sclk_prev <= sclk_lvl;
            slat_prev <= slat_lvl;
            word_vld  <= 1'b0;
            if (strobe_rise) begin
                if (cnt == CNT_W'(WORD_W)) begin
                    word_vld <= 1'b1;
                    word     <= sr;
                end
                sr  <= '0;
                cnt <= '0;
            end else if (bit_rise) begin
                sr <= {sr[WORD_W-2:0], sdat_lvl};
                if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
            end
        end
    end

    // R4
    clear_after_latch_chk: assert property (@(posedge clk) disable iff (rst)
        strobe_rise |=> (cnt == '0 && sr == '0));

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(CNT_MAX));

    // R2
    exact_len_chk: assert property (@(posedge clk) disable iff (rst)
        word_vld |-> $past(cnt) == CNT_W'(WORD_W));

    // R1
    shift_lsb_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_rise && !strobe_rise) |=> sr[0] == $past(sdat_lvl));

endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
    import ctl_pkg::*;
#(
    parameter int WORD_W = ctl_pkg::WORD_W,
    parameter int ADDR_W = ctl_pkg::ADDR_W,
    parameter int VOL_W  = ctl_pkg::VOL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word,
    output cfg_t              cfg,
    output logic [VOL_W-1:0]  vol_l,
    output logic [VOL_W-1:0]  vol_r
);

    localparam int DATA_W = WORD_W - ADDR_W;

    addr_e             addr;
    logic [DATA_W-1:0] data;

    assign addr = addr_e'(word[WORD_W-1 -: ADDR_W]);
    assign data = word[DATA_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= CFG_DEFAULT;
            vol_l <= VOL_DEFAULT;
            vol_r <= VOL_DEFAULT;
        end else if (word_vld) begin
            case (addr)
                ADDR_CFG:   cfg   <= to_cfg(data[CFG_W-1:0]);
                ADDR_VOL_L: vol_l <= data[VOL_W-1:0];
                ADDR_VOL_R: vol_r <= data[VOL_W-1:0];
                default:    ;
            endcase
        end
    end

    // R7
    rsvd_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (word_vld && addr == ADDR_RSVD) |=> ($stable(cfg) && $stable(vol_l) && $stable(vol_r)));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !word_vld |=> ($stable(cfg) && $stable(vol_l) && $stable(vol_r)));

    // R6
    vol_l_write_chk: assert property (@(posedge clk) disable iff (rst)
        (word_vld && addr == ADDR_VOL_L) |=> (vol_l == $past(data[VOL_W-1:0]) && $stable(vol_r)));

    // R9
    reset_default_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg == CFG_DEFAULT && vol_l == VOL_DEFAULT && vol_r == VOL_DEFAULT));

endmodule

// File: rtl/ctl_port.sv
module ctl_port
    import ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_clk,
    input  logic             ctl_dat,
    input  logic             ctl_latch,
    output logic [1:0]       fmt_mode,
    output logic [1:0]       word_len,
    output logic [1:0]       rate_sel,
    output logic [1:0]       deemph_sel,
    output logic             mute_l,
    output logic             mute_r,
    output logic             phase_inv,
    output logic             mclk_in_mode,
    output logic [VOL_W-1:0] vol_l,
    output logic [VOL_W-1:0] vol_r
);

    logic [2:0]        lvl;
    logic              word_vld;
    logic [WORD_W-1:0] word;
    cfg_t              cfg;

    ctl_sync #(.N(3), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({ctl_latch, ctl_dat, ctl_clk}),
        .level    (lvl)
    );

    ctl_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .sclk_lvl (lvl[0]),
        .sdat_lvl (lvl[1]),
        .slat_lvl (lvl[2]),
        .word_vld (word_vld),
        .word     (word)
    );

    ctl_regfile #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .VOL_W(VOL_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .word_vld (word_vld),
        .word     (word),
        .cfg      (cfg),
        .vol_l    (vol_l),
        .vol_r    (vol_r)
    );

    assign fmt_mode     = cfg.fmt;
    assign word_len     = cfg.wlen;
    assign rate_sel     = cfg.rate;
    assign deemph_sel   = cfg.deemph;
    assign mute_l       = cfg.mute_l;
    assign mute_r       = cfg.mute_r;
    assign phase_inv    = cfg.phase_inv;
    assign mclk_in_mode = cfg.mclk_in;

endmodule

// File: tb/tb_ctl_port.sv
module tb_ctl_port;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cclk = 1'b0, cdat = 1'b0, clat = 1'b0;

    logic [1:0]  fmt_mode, word_len, rate_sel, deemph_sel;
    logic        mute_l, mute_r, phase_inv, mclk_in_mode;
    logic [13:0] vol_l, vol_r;

    always #5 clk = ~clk;

    ctl_port dut (
        .clk(clk), .rst(rst), .ctl_clk(cclk), .ctl_dat(cdat), .ctl_latch(clat),
        .fmt_mode(fmt_mode), .word_len(word_len), .rate_sel(rate_sel),
        .deemph_sel(deemph_sel), .mute_l(mute_l), .mute_r(mute_r),
        .phase_inv(phase_inv), .mclk_in_mode(mclk_in_mode),
        .vol_l(vol_l), .vol_r(vol_r)
    );

    // Observed state: {cfg[11:0] in R8 bit order, vol_l, vol_r}
    wire [39:0] obs = {mclk_in_mode, phase_inv, mute_r, mute_l, deemph_sel,
                       rate_sel, word_len, fmt_mode, vol_l, vol_r};

    localparam logic [39:0] DEFAULTS = {12'h008, 14'h3FFF, 14'h3FFF};

    localparam int NV = 8;
    localparam logic [15:0] VEC_W [NV] = '{
        16'h4123, 16'h8ABC, 16'h0F5A, 16'hC777,
        16'h7FFF, 16'h3001, 16'h8000, 16'h0A95
    };
    localparam logic [39:0] VEC_E [NV] = '{
        {12'h008, 14'h0123, 14'h3FFF},
        {12'h008, 14'h0123, 14'h0ABC},
        {12'hF5A, 14'h0123, 14'h0ABC},
        {12'hF5A, 14'h0123, 14'h0ABC},
        {12'hF5A, 14'h3FFF, 14'h0ABC},
        {12'h001, 14'h3FFF, 14'h0ABC},
        {12'h001, 14'h3FFF, 14'h0000},
        {12'hA95, 14'h3FFF, 14'h0000}
    };
    localparam string VEC_R [NV] = '{"R6", "R6", "R8", "R7", "R6", "R8", "R6", "R8"};

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input logic [39:0] exp);
        n_run++;
        if (obs !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, obs, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [31:0] bits, input int n, input int idle);
        for (int i = n - 1; i >= 0; i--) begin
            cdat = bits[i];
            wait_clk(4);
            cclk = 1'b1;
            wait_clk(4);
            cclk = 1'b0;
            wait_clk(idle);
        end
    endtask

    task automatic pulse_latch();
        wait_clk(4);
        clat = 1'b1;
        wait_clk(4);
        clat = 1'b0;
        wait_clk(12);
    endtask

    task automatic write(input logic [15:0] w);
        send({16'h0, w}, 16, 0);
        pulse_latch();
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        chk("R9", DEFAULTS);

        for (int k = 0; k < NV; k++) begin
            write(VEC_W[k]);
            chk(VEC_R[k], VEC_E[k]);
        end

        // R1: bit order, a lone one at the far ends of the data field
        write(16'h4001);
        chk("R1", {12'hA95, 14'h0001, 14'h0000});
        write(16'h6000);
        chk("R1", {12'hA95, 14'h2000, 14'h0000});

        // R2: fifteen bits, then latch: nothing changes
        send(32'h0000_2AAA, 15, 0);
        pulse_latch();
        chk("R2", {12'hA95, 14'h2000, 14'h0000});
        // R4: next word is framed afresh
        write(16'h4111);
        chk("R4", {12'hA95, 14'h0111, 14'h0000});

        // R3: seventeen bits, then latch: nothing changes
        send(32'h0001_4222, 17, 0);
        pulse_latch();
        chk("R3", {12'hA95, 14'h0111, 14'h0000});
        write(16'h8333);
        chk("R4", {12'hA95, 14'h0111, 14'h0333});

        // R5: gated clock with long idle gaps
        send(32'h0000_004A, 8, 40);
        wait_clk(300);
        send(32'h0000_00BC, 8, 25);
        pulse_latch();
        chk("R5", {12'hA95, 14'h0ABC, 14'h0333});

        // R9: reset in the middle of a word drops the partial bits
        send(32'h0000_0155, 10, 0);
        rst = 1'b1;
        wait_clk(3);
        rst = 1'b0;
        wait_clk(2);
        chk("R9", DEFAULTS);
        send(32'h0000_002A, 6, 0);
        pulse_latch();
        chk("R2", DEFAULTS);
        write(16'h0002);
        chk("R8", {12'h002, 14'h3FFF, 14'h3FFF});

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule